// File: doc/BRIEF.md
# Receive Buffer Status Word Builder

This block forms the 32-bit completion status that a stream-to-memory engine writes back into each receive buffer descriptor. It watches the accepted beats of the incoming stream, their routing sideband (destination, stream identifier and user bits) and the last-beat marker. It also watches a buffer-full indication from the data mover and three error indications from the memory write path.

Whenever a buffer closes, the block issues one status word with a one-cycle valid strobe. A buffer closes on the beat that fills it or on the beat that ends the packet. The word reports whether the buffer opened the packet, whether it closed the packet, and the sideband values of the packet. The sideband values are those captured on the first beat of that packet.

An error produces one final word in the following cycle. That word carries the error flags and a clear completion bit. The block then halts and stays halted until reset, ignoring all further beats and errors.

Top module: `rx_status_builder`

## Requirements
- R1: After reset, `status_valid` is 0, `status_word` is 0 and `halted` is 0.
- R2: In every issued word, the destination is in bits 4:0, the stream identifier in bits 12:8 and the user bits in bits 19:16. Bits 7:5, 15:13 and 25:20 are 0.
- R3: The sideband fields of every word come from the first accepted beat of the packet. Sideband values on later beats of the same packet have no effect.
- R4: Bit 27 (start flag) is 1 only in the word of the buffer that holds the first beat of a packet.
- R5: Bit 26 (end flag) is 1 only in the word of the buffer that received the beat with `beat_last` high.
- R6: One cycle after each accepted beat with `beat_last` or `buf_full` high, `status_valid` is 1 for exactly that cycle. Other beats produce no strobe.
- R7: A word issued without an error has bit 31 (complete) set and bits 30:28 clear.
- R8: An error input issues a word in the next cycle with bit 28 = internal error, bit 29 = slave error, bit 30 = decode error, and bit 31 clear.
- R9: After an error word, `halted` stays 1 until reset, and no further word is issued whatever the inputs do.
- R10: A packet that fits in one buffer yields a single word with both bit 27 and bit 26 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| beat_valid | input | 1 | A stream beat is accepted this cycle |
| beat_last | input | 1 | Accepted beat ends the packet |
| buf_full | input | 1 | Accepted beat fills the current buffer |
| beat_dest | input | 5 | Destination routing sideband of the beat |
| beat_id | input | 5 | Stream identifier sideband of the beat |
| beat_user | input | 4 | User sideband of the beat |
| err_internal | input | 1 | Under-run or over-run detected |
| err_slave | input | 1 | Slave error response on a memory write |
| err_decode | input | 1 | Decode error response on a memory write |
| status_valid | output | 1 | One-cycle strobe: `status_word` is new |
| status_word | output | 32 | Descriptor status word |
| halted | output | 1 | Engine stopped after an error |

## Verification
The assertions assume that `buf_full` and `beat_last` are only meaningful together with `beat_valid`. They also assume that the sideband stays constant within a packet, as the stream rules require. The bench nonetheless changes the sideband on later beats, on purpose, to show that those values are ignored. Since every error halts the block, the stimulus applies reset again before each error scenario, so that each error is seen from a clean state. All inputs change on the falling edge, and outputs are sampled shortly after the rising edge that registers them.

// File: rtl/rx_status_builder.sv
module rx_status_builder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat_valid,
  input  logic        beat_last,
  input  logic        buf_full,
  input  logic [4:0]  beat_dest,
  input  logic [4:0]  beat_id,
  input  logic [3:0]  beat_user,
  input  logic        err_internal,
  input  logic        err_slave,
  input  logic        err_decode,
  output logic        status_valid,
  output logic [31:0] status_word,
  output logic        halted
);

  localparam logic [31:0] RSV_MASK = 32'h03F0_E0E0;

  logic       pkt_open;
  logic       sop_cur;
  logic [4:0] cap_dest;
  logic [4:0] cap_id;
  logic [3:0] cap_user;

  wire       live  = !halted;
  wire       beat  = beat_valid && live;
  wire       first = beat && !pkt_open;
  wire       close = beat && (beat_last || buf_full);
  wire [2:0] errs  = {err_decode, err_slave, err_internal} & {3{live}};
  wire       fault = |errs;

  wire [4:0] f_dest = first ? beat_dest : cap_dest;
  wire [4:0] f_id   = first ? beat_id   : cap_id;
  wire [3:0] f_user = first ? beat_user : cap_user;
  wire       f_sop  = first || sop_cur;
  wire       f_eop  = close && beat_last;

  wire [31:0] next_word = {!fault, errs, f_sop, f_eop, 6'b0, f_user,
                           3'b0, f_id, 3'b0, f_dest};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_valid <= 1'b0;
      status_word  <= '0;
      halted       <= 1'b0;
      pkt_open     <= 1'b0;
      sop_cur      <= 1'b0;
      cap_dest     <= '0;
      cap_id       <= '0;
      cap_user     <= '0;
    end else begin
      status_valid <= close || fault;
      if (close || fault) status_word <= next_word;
      if (fault) halted <= 1'b1;
      if (first) begin
        cap_dest <= beat_dest;
        cap_id   <= beat_id;
        cap_user <= beat_user;
      end
      if (beat) pkt_open <= !beat_last;
      if (close) sop_cur <= 1'b0;
      else if (first) sop_cur <= 1'b1;
    end
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> ((status_word & RSV_MASK) == 32'h0));

  a_r6_strobe_after_close: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && (beat_last || buf_full) && !halted) |=> status_valid);

  a_r7_clean_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && !halted) |-> (status_word[31] && status_word[30:28] == 3'b000));

  a_r8_error_word: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && (err_internal || err_slave || err_decode)) |=>
      (status_valid && halted && !status_word[31]));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r9_silent_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !status_valid);

endmodule

// File: tb/sim_rx_status_builder.sv
module sim_rx_status_builder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        beat_valid, beat_last, buf_full;
  logic [4:0]  beat_dest, beat_id;
  logic [3:0]  beat_user;
  logic        err_internal, err_slave, err_decode;
  logic        status_valid;
  logic [31:0] status_word;
  logic        halted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_status_builder u0 (.*);

  function automatic logic [31:0] mk(input bit cmp, input bit de, input bit se,
      input bit ie, input bit sop, input bit eop, input logic [3:0] user,
      input logic [4:0] id, input logic [4:0] dest);
    return {cmp, de, se, ie, sop, eop, 6'b0, user, 3'b0, id, 3'b0, dest};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    beat_valid = 0; beat_last = 0; buf_full = 0;
    beat_dest = 0; beat_id = 0; beat_user = 0;
    err_internal = 0; err_slave = 0; err_decode = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle_in(); rst_n = 0;
    step(); step();
    @(negedge clk); rst_n = 1;
  endtask

  task automatic beat(input bit last, input bit full, input logic [4:0] d,
                      input logic [4:0] i, input logic [3:0] u);
    @(negedge clk);
    idle_in();
    beat_valid = 1; beat_last = last; buf_full = full;
    beat_dest = d; beat_id = i; beat_user = u;
    step();
    @(negedge clk); idle_in();
  endtask

  task automatic t_reset();
    do_reset();
    step();
    chk("R1 valid", 32'(status_valid), 0);
    chk("R1 word", status_word, 0);
    chk("R1 halted", 32'(halted), 0);
  endtask

  task automatic t_single();
    beat(1, 0, 5'h15, 5'h0A, 4'h9);
    chk("R6 strobe", 32'(status_valid), 1);
    chk("R10 R2 R7 single buffer word", status_word, mk(1,0,0,0,1,1,4'h9,5'h0A,5'h15));
    step();
    chk("R6 strobe one cycle", 32'(status_valid), 0);
  endtask

  task automatic t_multi();
    beat(0, 0, 5'h03, 5'h07, 4'h5);
    chk("R6 no strobe mid buffer", 32'(status_valid), 0);
    beat(0, 1, 5'h1F, 5'h1F, 4'hF);
    chk("R6 strobe on full", 32'(status_valid), 1);
    chk("R3 R4 first buffer", status_word, mk(1,0,0,0,1,0,4'h5,5'h07,5'h03));
    beat(0, 1, 5'h11, 5'h02, 4'h1);
    chk("R4 R5 middle buffer", status_word, mk(1,0,0,0,0,0,4'h5,5'h07,5'h03));
    beat(1, 0, 5'h00, 5'h00, 4'h0);
    chk("R5 R3 last buffer", status_word, mk(1,0,0,0,0,1,4'h5,5'h07,5'h03));
    beat(1, 1, 5'h1E, 5'h01, 4'hA);
    chk("R4 R10 next packet", status_word, mk(1,0,0,0,1,1,4'hA,5'h01,5'h1E));
  endtask

  task automatic t_err_slave();
    do_reset();
    err_slave = 1;
    step();
    chk("R8 slave word", status_word, mk(0,0,1,0,0,0,4'h0,5'h00,5'h00));
    chk("R8 strobe", 32'(status_valid), 1);
    chk("R9 halted", 32'(halted), 1);
    beat(1, 0, 5'h04, 5'h04, 4'h4);
    chk("R9 no word after halt", 32'(status_valid), 0);
    chk("R9 word held", status_word, mk(0,0,1,0,0,0,4'h0,5'h00,5'h00));
  endtask

  task automatic t_err_decode();
    do_reset();
    err_decode = 1;
    step();
    chk("R8 decode word", status_word, mk(0,1,0,0,0,0,4'h0,5'h00,5'h00));
    @(negedge clk); idle_in(); err_internal = 1;
    step();
    chk("R9 error ignored once halted", 32'(status_valid), 0);
  endtask

  task automatic t_err_internal();
    do_reset();
    beat(0, 0, 5'h0C, 5'h13, 4'h6);
    @(negedge clk); idle_in(); err_internal = 1;
    step();
    chk("R8 internal word", status_word, mk(0,0,0,1,1,0,4'h6,5'h13,5'h0C));
    @(negedge clk); idle_in();
    step(); step();
    chk("R9 still halted", 32'(halted), 1);
    chk("R9 still silent", 32'(status_valid), 0);
  endtask

  initial begin
    idle_in();
    rst_n = 0;
    t_reset();
    t_single();
    t_multi();
    t_err_slave();
    t_err_decode();
    t_err_internal();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule